// File: doc/BRIEF.md
# Two-level branch direction predictor

This block guesses, in the fetch cycle, whether a conditional branch will be taken. It keeps a table of small four-state hysteresis machines built from flip-flops. A row of the table is chosen by the low word-address bits of the fetch PC. Within that row, a short global history register picks one of several machines; the register holds the outcomes of the most recently resolved branches. The lookup is purely combinational. The history value used for the lookup is also returned, so the pipeline can carry it along with the branch.

When a branch resolves in the execute stage, the pipeline presents the branch PC, the history value that came with the branch, the real outcome and a valid strobe. On the next clock edge the addressed machine steps and the history register shifts in the outcome. The history value supplied with the branch selects the machine, not the current history. Younger branches that were looked up in the meantime therefore cannot steer the update onto the wrong entry. Branches that share low PC bits share machines; this can cost accuracy, but never correctness.

Each machine has four states, named and encoded as follows:
- NT_STRONG = 0
- NT_WEAK = 1
- T_WEAK = 2
- T_STRONG = 3

The transitions are:
- Outcome agrees with a strong state: the machine stays where it is (hold).
- Outcome agrees with a weak state: the machine moves to the strong state of the same direction (reinforce).
- Outcome disagrees with a strong state: the machine moves to the weak state of the same direction (weaken).
- Outcome disagrees with a weak state: the machine moves to the strong state of the opposite direction (flip).

Top module: `bp_dir_predictor`

## Requirements
- R1: After reset every machine is in NT_WEAK and the history register is 0, so every lookup predicts not taken and lk_hist reads 0.
- R2: The row index is lk_pc[IDX_W+1:2] (and up_pc[IDX_W+1:2] for updates). PC bits 1:0 and bits above IDX_W+1 have no effect, so PCs that differ only in those bits alias to the same machines.
- R3: Within a row, the current history value h selects machine h. lk_taken is 1 exactly when that machine is in T_WEAK or T_STRONG, and lk_hist outputs h.
- R4: On a clock edge with up_valid=1 the history becomes {old_hist[HIST_W-2:0], up_taken}, where 1 means taken. With up_valid=0 the history is unchanged.
- R5: An update moves the addressed machine as follows (encoding NT_STRONG=0, NT_WEAK=1, T_WEAK=2, T_STRONG=3). Taken: 0→1, 1→3, 2→3, 3→3. Not taken: 3→2, 2→0, 1→0, 0→0. As a result, the predicted direction changes only after two mispredictions in a row.
- R6: An update writes only the machine at row up_pc[IDX_W+1:2] and set up_hist, whatever the current history is. All other machines keep their state.
- R7: When a lookup and an update address the same machine in one cycle, lk_taken shows the state from before the update. The new state is visible from the next cycle on.
- R8: With up_valid=0, no machine changes state, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to predict for |
| lk_taken | output | 1 | Prediction, 1 = taken |
| lk_hist | output | HIST_W | History value used by this lookup, to be carried with the branch |
| up_valid | input | 1 | A branch resolved this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_hist | input | HIST_W | History value captured when the branch was looked up |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The lookup port only shows the machine selected by the current history. Any machine in another history set is therefore hidden behind the history register, and the hardest case is checking a machine whose set differs from the current history.

The bench handles this in two steps. It first writes a target machine through up_hist. It then steers the history to the wanted value with two updates on a scratch row, and only then looks the target up. This is how the hysteresis walk, the per-set separation and a same-cycle lookup/update collision are reached. A long pseudo-random phase follows, with arbitrary up_hist values, aliasing high PC bits and idle cycles. In it, every lookup is compared against an arithmetic model of the table and the history.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        ST_NT_STRONG = 2'd0,
        ST_NT_WEAK   = 2'd1,
        ST_T_WEAK    = 2'd2,
        ST_T_STRONG  = 2'd3
    } hyst_state_e;
endpackage

// File: rtl/bp_hyst_entry.sv
module bp_hyst_entry
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic upd_taken,
    output logic pred_taken
);
    hyst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NT_WEAK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            unique case (state_q)
                ST_NT_STRONG: state_d = upd_taken ? ST_NT_WEAK  : ST_NT_STRONG;
                ST_NT_WEAK:   state_d = upd_taken ? ST_T_STRONG : ST_NT_STRONG;
                ST_T_WEAK:    state_d = upd_taken ? ST_T_STRONG : ST_NT_STRONG;
                ST_T_STRONG:  state_d = upd_taken ? ST_T_STRONG : ST_T_WEAK;
                default:      state_d = ST_NT_WEAK;
            endcase
        end
    end

    always_comb begin
        pred_taken = (state_q == ST_T_WEAK) || (state_q == ST_T_STRONG);
    end

    // R5: direction flips only out of a weak state, after two misses in a row
    assert_flip_from_weak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken != $past(pred_taken)) |->
            ($past(state_q) == ST_T_WEAK || $past(state_q) == ST_NT_WEAK));

    // R8: no update strobe, no state change
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_en) |-> $stable(state_q));
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
    end

    assign hist = hist_q;

    // R4: one outcome shifted in per resolved branch
    assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shift_en) |-> (hist == {$past(hist[HIST_W-2:0]), $past(shift_bit)}));

    assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shift_en) |-> $stable(hist));
endmodule

// File: rtl/bp_hyst_table.sv
module bp_hyst_table #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W+HIST_W-1:0] rd_sel,
    output logic                    rd_taken,
    input  logic                    wr_en,
    input  logic [IDX_W+HIST_W-1:0] wr_sel,
    input  logic                    wr_taken
);
    localparam int ENTRIES = 1 << (IDX_W + HIST_W);

    logic [ENTRIES-1:0] pred_vec;
    logic [ENTRIES-1:0] we_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign we_vec[e] = wr_en && (wr_sel == e[IDX_W+HIST_W-1:0]);
        bp_hyst_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_en     (we_vec[e]),
            .upd_taken  (wr_taken),
            .pred_taken (pred_vec[e])
        );
    end

    assign rd_taken = pred_vec[rd_sel];

    // R6: a resolve touches at most one machine
    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R6: strobe present means exactly one machine enabled
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(we_vec) == 1));
endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken
);
    localparam int SEL_W = IDX_W + HIST_W;

    logic [HIST_W-1:0] cur_hist;
    logic [SEL_W-1:0]  rd_sel;
    logic [SEL_W-1:0]  wr_sel;
    logic              lk_unused;

    bp_ghist #(.HIST_W(HIST_W)) u_ghist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (up_valid),
        .shift_bit (up_taken),
        .hist      (cur_hist)
    );

    assign rd_sel  = {lk_pc[IDX_W+1:2], cur_hist};
    assign wr_sel  = {up_pc[IDX_W+1:2], up_hist};
    assign lk_hist = cur_hist;

    assign lk_unused = ^{lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0],
                         up_pc[PC_W-1:IDX_W+2], up_pc[1:0]};

    bp_hyst_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel),
        .rd_taken (lk_taken),
        .wr_en    (up_valid),
        .wr_sel   (wr_sel),
        .wr_taken (up_taken)
    );

    // R1: prediction never unknown once out of reset
    assert_pred_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({lk_taken, lk_hist}));
endmodule

// File: tb/bp_dir_predictor_tb_top.sv
module bp_dir_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 3;
    localparam int HIST_W = 2;
    localparam int ENT    = 1 << (IDX_W + HIST_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic              lk_taken;
    logic [HIST_W-1:0] lk_hist;
    logic              up_valid = 1'b0;
    logic [PC_W-1:0]   up_pc = '0;
    logic [HIST_W-1:0] up_hist = '0;
    logic              up_taken = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int tbl [ENT];
    int hist_m = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc),
        .up_hist(up_hist), .up_taken(up_taken)
    );

    function automatic int next_state(int s, bit t);
        if (t) return (s == 0) ? 1 : 3;
        return (s == 3) ? 2 : 0;
    endfunction

    function automatic int row_of(logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic step(input logic [PC_W-1:0] lpc, input bit uv,
                        input logic [PC_W-1:0] upc, input int uh,
                        input bit ut, input string tag);
        int  sel;
        bit  exp_t;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc;
        up_hist = uh[HIST_W-1:0]; up_taken = ut;
        #1;
        sel   = row_of(lpc) * 4 + hist_m;
        exp_t = (tbl[sel] >= 2);
        n_vec++;
        if (lk_taken !== exp_t) begin
            n_bad++;
            $display("FAIL %s lk_taken pc=%h actual=%b expected=%b", tag, lpc, lk_taken, exp_t);
        end
        n_vec++;
        if (lk_hist !== hist_m[HIST_W-1:0]) begin
            n_bad++;
            $display("FAIL %s lk_hist actual=%0d expected=%0d", tag, lk_hist, hist_m);
        end
        if (uv) begin
            sel = row_of(upc) * 4 + uh;
            tbl[sel] = next_state(tbl[sel], ut);
            hist_m = ((hist_m << 1) | int'(ut)) & 3;
        end
    endtask

    // steer the history with two updates on scratch row 7
    task automatic set_hist(input int h, input string tag);
        step(32'h0, 1'b1, 32'h1C, 0, h[1], tag);
        step(32'h0, 1'b1, 32'h1C, 0, h[0], tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENT; i++) tbl[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across every row
        for (int r = 0; r < (1 << IDX_W); r++)
            step(32'(r << 2), 1'b0, '0, 0, 1'b0, "R1");

        // R5: hysteresis walk on row 5, set 3, observed after steering history to 3
        begin
            bit seq [12] = '{1,1,0,0,0,1,0,1,1,0,1,0};
            for (int i = 0; i < 12; i++) begin
                step(32'h0, 1'b1, 32'h14, 3, seq[i], "R5");
                set_hist(3, "R4");
                step(32'h14, 1'b0, '0, 0, 1'b0, "R5");
            end
        end

        // R7: collide lookup and update on row 5 set 3 (history is 3 here)
        step(32'h14, 1'b1, 32'h14, 3, ~(tbl[5*4+3] >= 2), "R7");
        set_hist(3, "R4");
        step(32'h14, 1'b0, '0, 0, 1'b0, "R7");

        // R3/R6: distinct patterns per set on row 2, then read each set
        for (int h = 0; h < 4; h++) begin
            step(32'h0, 1'b1, 32'h8, h, h[0], "R6");
            step(32'h0, 1'b1, 32'h8, h, h[0], "R6");
        end
        for (int h = 0; h < 4; h++) begin
            set_hist(h, "R4");
            step(32'h8, 1'b0, '0, 0, 1'b0, "R3");
        end

        // R2: aliasing through high and byte-offset bits
        step(32'h0, 1'b1, 32'hABC0_0007, 1, 1'b1, "R2");
        step(32'h0, 1'b1, 32'hFF00_0004, 2, 1'b1, "R2");
        set_hist(2, "R4");
        step(32'h5500_0006, 1'b0, '0, 0, 1'b0, "R2");

        // R8: busy update fields with no strobe
        for (int i = 0; i < 64; i++)
            step(rnd(), 1'b0, rnd(), i & 3, i[0], "R8");

        // R6: long pseudo-random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a = rnd();
            logic [31:0] b = rnd();
            step(a, b[0] | b[1], rnd(), int'(b[3:2]), b[4], "R6");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule